// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor. It holds the single interrupt that the processor is being offered, the priority the processor is currently running at, and the priority of a software-raised inter-processor interrupt (IPI). A source controller offers interrupts with a source number and a priority. In the same cycle the block either takes the offer or turns it back with a reject strobe. When a more favoured interrupt takes the one slot, the block rejects the source that was already there. Priorities are inverted: a lower value is more favoured, and 0xff is the least favoured value and acts as a mask.

The processor drives four operations: it writes its running priority, writes the IPI priority, accepts (reads) the pending interrupt, and signals end of interrupt. When the slot is empty and the priority threshold rises, the block asks the source controller to resend rejected work. Before it does so it checks again whether the IPI can now be presented. An accept makes the accepted interrupt's priority the new running priority.

Top module: `irq_present_ctrl`

## Requirements
- R1: After reset the 32-bit state word is 0, `irq_o` is low and no strobe is active. The pending priority and the IPI priority both reset to 0xff.
- R2: The state word carries the running priority in bits 31:24 and the pending source number in bits 23:0, and a source field of 0 means nothing is pending. `irq_o` is high exactly when the source field is nonzero.
- R3: An offer is rejected in its own cycle, with `reject_o` high, `reject_src_o` equal to the offered source and the state unchanged, in either of two cases: its priority is not below the running priority, or a source is pending with a priority at or below the offered one.
- R4: An offer that is not rejected rejects any source already pending in the same cycle. The next cycle shows the new source in the state word and `irq_o` high.
- R5: An accept returns the current state word on `accept_data_o` in its own cycle. From the next cycle the running priority is the old pending priority, the source field is 0, `irq_o` is low and the pending priority is 0xff.
- R6: An end-of-interrupt write pulses `eoi_o` in its own cycle with `eoi_src_o` equal to bits 23:0 of the written word. From the next cycle the running priority equals bits 31:24 of the written word.
- R7: If nothing is pending after an end-of-interrupt, `resend_o` pulses in the same cycle. If the IPI priority is below the new running priority, the IPI is also presented.
- R8: A priority write below the current running priority clears a pending source whose priority is not below the new value. It rejects that source in the same cycle and lowers `irq_o`. A more favoured pending source stays, and an empty slot produces neither reject nor resend.
- R9: A priority write that is equal to or above the current running priority, made while nothing is pending, pulses `resend_o` and re-checks the IPI.
- R10: An IPI priority write below the running priority presents source number 2 with that priority and rejects any displaced source. Nothing happens if a source is already pending at an equal or more favoured priority.
- R11: If several operations arrive in one cycle, only one is performed, chosen in this order: accept, end-of-interrupt, priority write, IPI write, offer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offer_valid_i | input | 1 | Offer from the source controller |
| offer_src_i | input | 24 | Offered source number (nonzero) |
| offer_prio_i | input | 8 | Offered priority |
| cppr_wr_i | input | 1 | Running-priority write |
| cppr_data_i | input | 8 | New running priority |
| ipi_wr_i | input | 1 | IPI priority write |
| ipi_prio_i | input | 8 | New IPI priority |
| accept_i | input | 1 | Accept (read) of the pending interrupt |
| accept_data_o | output | 32 | Current state word |
| eoi_wr_i | input | 1 | End-of-interrupt write |
| eoi_data_i | input | 32 | Priority in 31:24, finished source in 23:0 |
| irq_o | output | 1 | Interrupt line to the processor |
| reject_o | output | 1 | Reject strobe to the source controller |
| reject_src_o | output | 24 | Rejected source number |
| resend_o | output | 1 | Resend request strobe |
| eoi_o | output | 1 | End-of-interrupt strobe to the source controller |
| eoi_src_o | output | 24 | Finished source number |

## Verification
The assertions assume that offered source numbers are nonzero, so the empty-slot encoding is never offered as a real source. Each property that ties a strobe to an operation is qualified on that operation being the only one active that cycle. The directed stimulus drives one operation per cycle throughout, with one exception: a single deliberate collision of an accept with an offer, which exercises the selection order. The stimulus also uses only nonzero source numbers.

// File: rtl/irq_pres_pkg.sv
package irq_pres_pkg;
  parameter int unsigned PRIO_W = 8;
  parameter int unsigned SRC_W  = 24;
  parameter int unsigned WORD_W = PRIO_W + SRC_W;

  localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ACCEPT,
    OP_EOI,
    OP_CPPR,
    OP_IPI,
    OP_OFFER
  } op_e;
endpackage

// File: rtl/irq_pres_op_sel.sv
module irq_pres_op_sel
  import irq_pres_pkg::*;
(
  input  logic accept_i,
  input  logic eoi_wr_i,
  input  logic cppr_wr_i,
  input  logic ipi_wr_i,
  input  logic offer_valid_i,
  output op_e  op_o
);
  // fixed order when operations collide
  always_comb begin
    if (accept_i)           op_o = OP_ACCEPT;
    else if (eoi_wr_i)      op_o = OP_EOI;
    else if (cppr_wr_i)     op_o = OP_CPPR;
    else if (ipi_wr_i)      op_o = OP_IPI;
    else if (offer_valid_i) op_o = OP_OFFER;
    else                    op_o = OP_NONE;
  end
endmodule

// File: rtl/irq_pres_engine.sv
module irq_pres_engine
  import irq_pres_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  op_e               op_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  input  logic [PRIO_W-1:0] cppr_data_i,
  input  logic [PRIO_W-1:0] ipi_prio_i,
  input  logic [WORD_W-1:0] eoi_data_i,
  input  logic [PRIO_W-1:0] cppr_q_i,
  input  logic [SRC_W-1:0]  src_q_i,
  input  logic [PRIO_W-1:0] pend_q_i,
  input  logic [PRIO_W-1:0] mfrr_q_i,
  input  logic              irq_q_i,
  output logic [PRIO_W-1:0] cppr_d_o,
  output logic [SRC_W-1:0]  src_d_o,
  output logic [PRIO_W-1:0] pend_d_o,
  output logic [PRIO_W-1:0] mfrr_d_o,
  output logic              irq_d_o,
  output logic              reject_o,
  output logic [SRC_W-1:0]  reject_src_o,
  output logic              resend_o,
  output logic              eoi_o,
  output logic [SRC_W-1:0]  eoi_src_o
);
  localparam logic [SRC_W-1:0] IPI_NR = SRC_W'(IPI_SRC);

  logic              busy;
  logic              do_resend;
  logic [PRIO_W-1:0] rs_cppr;

  assign busy = (src_q_i != '0);

  always_comb begin
    cppr_d_o     = cppr_q_i;
    src_d_o      = src_q_i;
    pend_d_o     = pend_q_i;
    mfrr_d_o     = mfrr_q_i;
    irq_d_o      = irq_q_i;
    reject_o     = 1'b0;
    reject_src_o = '0;
    resend_o     = 1'b0;
    eoi_o        = 1'b0;
    eoi_src_o    = '0;
    do_resend    = 1'b0;
    rs_cppr      = cppr_q_i;

    unique case (op_i)
      OP_OFFER: begin
        if ((offer_prio_i >= cppr_q_i) || (busy && (pend_q_i <= offer_prio_i))) begin
          reject_o     = 1'b1;
          reject_src_o = offer_src_i;
        end else begin
          if (busy) begin
            reject_o     = 1'b1;
            reject_src_o = src_q_i;
          end
          src_d_o  = offer_src_i;
          pend_d_o = offer_prio_i;
          irq_d_o  = 1'b1;
        end
      end
      OP_IPI: begin
        mfrr_d_o = ipi_prio_i;
        if ((ipi_prio_i < cppr_q_i) && !(busy && (pend_q_i <= ipi_prio_i))) begin
          if (busy) begin
            reject_o     = 1'b1;
            reject_src_o = src_q_i;
          end
          src_d_o  = IPI_NR;
          pend_d_o = ipi_prio_i;
          irq_d_o  = 1'b1;
        end
      end
      OP_CPPR: begin
        cppr_d_o = cppr_data_i;
        if (cppr_data_i < cppr_q_i) begin
          if (busy && (cppr_data_i <= pend_q_i)) begin
            reject_o     = 1'b1;
            reject_src_o = src_q_i;
            src_d_o      = '0;
            pend_d_o     = PRIO_MASKED;
            irq_d_o      = 1'b0;
          end
        end else if (!busy) begin
          do_resend = 1'b1;
          rs_cppr   = cppr_data_i;
        end
      end
      OP_ACCEPT: begin
        irq_d_o  = 1'b0;
        cppr_d_o = pend_q_i;
        src_d_o  = '0;
        pend_d_o = PRIO_MASKED;
      end
      OP_EOI: begin
        cppr_d_o  = eoi_data_i[WORD_W-1 -: PRIO_W];
        eoi_o     = 1'b1;
        eoi_src_o = eoi_data_i[SRC_W-1:0];
        if (!busy) begin
          do_resend = 1'b1;
          rs_cppr   = eoi_data_i[WORD_W-1 -: PRIO_W];
        end
      end
      default: ;
    endcase

    // slot is empty here, so presenting the IPI displaces nothing
    if (do_resend) begin
      resend_o = 1'b1;
      if (mfrr_q_i < rs_cppr) begin
        src_d_o  = IPI_NR;
        pend_d_o = mfrr_q_i;
        irq_d_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_pres_state.sv
module irq_pres_state
  import irq_pres_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRIO_W-1:0] cppr_d_i,
  input  logic [SRC_W-1:0]  src_d_i,
  input  logic [PRIO_W-1:0] pend_d_i,
  input  logic [PRIO_W-1:0] mfrr_d_i,
  input  logic              irq_d_i,
  output logic [PRIO_W-1:0] cppr_q_o,
  output logic [SRC_W-1:0]  src_q_o,
  output logic [PRIO_W-1:0] pend_q_o,
  output logic [PRIO_W-1:0] mfrr_q_o,
  output logic              irq_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q_o <= '0;
      src_q_o  <= '0;
      pend_q_o <= PRIO_MASKED;
      mfrr_q_o <= PRIO_MASKED;
      irq_q_o  <= 1'b0;
    end else begin
      cppr_q_o <= cppr_d_i;
      src_q_o  <= src_d_i;
      pend_q_o <= pend_d_i;
      mfrr_q_o <= mfrr_d_i;
      irq_q_o  <= irq_d_i;
    end
  end
endmodule

// File: rtl/irq_present_ctrl.sv
module irq_present_ctrl
  import irq_pres_pkg::*;
#(
  parameter int unsigned IPI_SRC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              offer_valid_i,
  input  logic [SRC_W-1:0]  offer_src_i,
  input  logic [PRIO_W-1:0] offer_prio_i,
  input  logic              cppr_wr_i,
  input  logic [PRIO_W-1:0] cppr_data_i,
  input  logic              ipi_wr_i,
  input  logic [PRIO_W-1:0] ipi_prio_i,
  input  logic              accept_i,
  output logic [WORD_W-1:0] accept_data_o,
  input  logic              eoi_wr_i,
  input  logic [WORD_W-1:0] eoi_data_i,
  output logic              irq_o,
  output logic              reject_o,
  output logic [SRC_W-1:0]  reject_src_o,
  output logic              resend_o,
  output logic              eoi_o,
  output logic [SRC_W-1:0]  eoi_src_o
);
  op_e               op;
  logic [PRIO_W-1:0] cppr_q, cppr_d, pend_q, pend_d, mfrr_q, mfrr_d;
  logic [SRC_W-1:0]  src_q, src_d;
  logic              irq_q, irq_d;

  irq_pres_op_sel u_op_sel (
    .accept_i      (accept_i),
    .eoi_wr_i      (eoi_wr_i),
    .cppr_wr_i     (cppr_wr_i),
    .ipi_wr_i      (ipi_wr_i),
    .offer_valid_i (offer_valid_i),
    .op_o          (op)
  );

  irq_pres_engine #(.IPI_SRC(IPI_SRC)) u_engine (
    .op_i         (op),
    .offer_src_i  (offer_src_i),
    .offer_prio_i (offer_prio_i),
    .cppr_data_i  (cppr_data_i),
    .ipi_prio_i   (ipi_prio_i),
    .eoi_data_i   (eoi_data_i),
    .cppr_q_i     (cppr_q),
    .src_q_i      (src_q),
    .pend_q_i     (pend_q),
    .mfrr_q_i     (mfrr_q),
    .irq_q_i      (irq_q),
    .cppr_d_o     (cppr_d),
    .src_d_o      (src_d),
    .pend_d_o     (pend_d),
    .mfrr_d_o     (mfrr_d),
    .irq_d_o      (irq_d),
    .reject_o     (reject_o),
    .reject_src_o (reject_src_o),
    .resend_o     (resend_o),
    .eoi_o        (eoi_o),
    .eoi_src_o    (eoi_src_o)
  );

  irq_pres_state u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cppr_d_i (cppr_d),
    .src_d_i  (src_d),
    .pend_d_i (pend_d),
    .mfrr_d_i (mfrr_d),
    .irq_d_i  (irq_d),
    .cppr_q_o (cppr_q),
    .src_q_o  (src_q),
    .pend_q_o (pend_q),
    .mfrr_q_o (mfrr_q),
    .irq_q_o  (irq_q)
  );

  assign accept_data_o = {cppr_q, src_q};
  assign irq_o         = irq_q;
endmodule

// File: rtl/irq_present_ctrl_chk.sv
module irq_present_ctrl_chk
  import irq_pres_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              offer_valid_i,
  input logic [SRC_W-1:0]  offer_src_i,
  input logic [PRIO_W-1:0] offer_prio_i,
  input logic              cppr_wr_i,
  input logic [PRIO_W-1:0] cppr_data_i,
  input logic              ipi_wr_i,
  input logic [PRIO_W-1:0] ipi_prio_i,
  input logic              accept_i,
  input logic [WORD_W-1:0] accept_data_o,
  input logic              eoi_wr_i,
  input logic [WORD_W-1:0] eoi_data_i,
  input logic              irq_o,
  input logic              reject_o,
  input logic [SRC_W-1:0]  reject_src_o,
  input logic              resend_o,
  input logic              eoi_o,
  input logic [SRC_W-1:0]  eoi_src_o
);
  logic [PRIO_W-1:0] cur_cppr;
  logic [SRC_W-1:0]  cur_src;
  logic              only_offer, only_cppr, only_ipi, only_eoi;

  assign cur_cppr   = accept_data_o[WORD_W-1 -: PRIO_W];
  assign cur_src    = accept_data_o[SRC_W-1:0];
  assign only_offer = offer_valid_i && !accept_i && !eoi_wr_i && !cppr_wr_i && !ipi_wr_i;
  assign only_cppr  = cppr_wr_i && !accept_i && !eoi_wr_i;
  assign only_ipi   = ipi_wr_i && !accept_i && !eoi_wr_i && !cppr_wr_i;
  assign only_eoi   = eoi_wr_i && !accept_i;

  assert_irq_tracks_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (cur_src != '0));

  assert_offer_reject_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_offer && (offer_prio_i >= cur_cppr)) |-> (reject_o && reject_src_o == offer_src_i));

  assert_offer_keeps_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_offer && (offer_prio_i >= cur_cppr)) |=> $stable(accept_data_o));

  assert_accept_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> (cur_src == '0 && !irq_o));

  assert_eoi_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_eoi |-> (eoi_o && eoi_src_o == eoi_data_i[SRC_W-1:0]));

  assert_eoi_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    only_eoi |=> (cur_cppr == $past(eoi_data_i[WORD_W-1 -: PRIO_W])));

  assert_lower_empty_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_cppr && (cppr_data_i < cur_cppr) && (cur_src == '0)) |-> (!reject_o && !resend_o));

  assert_raise_empty_resend_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_cppr && (cppr_data_i >= cur_cppr) && (cur_src == '0)) |-> resend_o);

  assert_ipi_presented_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (only_ipi && (ipi_prio_i < cur_cppr) && (cur_src == '0)) |=> (cur_src == SRC_W'(2) && irq_o));
endmodule

bind irq_present_ctrl irq_present_ctrl_chk u_chk (.*);

// File: tb/irq_present_ctrl_bench.sv
module irq_present_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        offer_valid_i = 1'b0;
  logic [23:0] offer_src_i = '0;
  logic [7:0]  offer_prio_i = '0;
  logic        cppr_wr_i = 1'b0;
  logic [7:0]  cppr_data_i = '0;
  logic        ipi_wr_i = 1'b0;
  logic [7:0]  ipi_prio_i = '0;
  logic        accept_i = 1'b0;
  logic [31:0] accept_data_o;
  logic        eoi_wr_i = 1'b0;
  logic [31:0] eoi_data_i = '0;
  logic        irq_o, reject_o, resend_o, eoi_o;
  logic [23:0] reject_src_o, eoi_src_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // values captured mid-cycle during the operation
  logic        c_rej, c_rs, c_eoi;
  logic [23:0] c_rej_src, c_eoi_src;
  logic [31:0] c_acc;

  always #10 clk_i = ~clk_i;

  irq_present_ctrl u_irq_present_ctrl (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs set at a falling edge; capture strobes, cross the rising edge, clear inputs
  task automatic step();
    #5;
    c_rej = reject_o; c_rej_src = reject_src_o; c_rs = resend_o;
    c_eoi = eoi_o; c_eoi_src = eoi_src_o; c_acc = accept_data_o;
    @(negedge clk_i);
    offer_valid_i = 0; cppr_wr_i = 0; ipi_wr_i = 0; accept_i = 0; eoi_wr_i = 0;
    #2;
  endtask

  task automatic offer(input logic [23:0] s, input logic [7:0] p);
    offer_valid_i = 1; offer_src_i = s; offer_prio_i = p; step();
  endtask
  task automatic wr_cppr(input logic [7:0] c);
    cppr_wr_i = 1; cppr_data_i = c; step();
  endtask
  task automatic wr_ipi(input logic [7:0] m);
    ipi_wr_i = 1; ipi_prio_i = m; step();
  endtask
  task automatic do_accept();
    accept_i = 1; step();
  endtask
  task automatic do_eoi(input logic [31:0] w);
    eoi_wr_i = 1; eoi_data_i = w; step();
  endtask

  task automatic t_reset();
    chk("R1 word", accept_data_o, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 strobes", {29'b0, reject_o, resend_o, eoi_o}, 0);
  endtask

  task automatic t_offer_reject();
    offer(24'd10, 8'h05);
    chk("R3 reject", {31'b0, c_rej}, 1);
    chk("R3 reject src", {8'b0, c_rej_src}, 32'd10);
    chk("R3 state kept", accept_data_o, 32'h0);
  endtask

  task automatic t_raise_resend();
    wr_cppr(8'hff);
    chk("R9 resend", {31'b0, c_rs}, 1);
    chk("R9 word", accept_data_o, 32'hff000000);
  endtask

  task automatic t_offer_take();
    offer(24'd20, 8'h08);
    chk("R4 no reject", {31'b0, c_rej}, 0);
    chk("R4 word", accept_data_o, 32'hff000014);
    chk("R2 irq high", {31'b0, irq_o}, 1);
    offer(24'd21, 8'h04);
    chk("R4 displaced", {31'b0, c_rej}, 1);
    chk("R4 displaced src", {8'b0, c_rej_src}, 32'd20);
    chk("R4 word2", accept_data_o, 32'hff000015);
    offer(24'd22, 8'h04);
    chk("R3 equal pending", {8'b0, c_rej_src}, 32'd22);
    chk("R3 equal word", accept_data_o, 32'hff000015);
  endtask

  task automatic t_accept_eoi();
    do_accept();
    chk("R5 read", c_acc, 32'hff000015);
    chk("R5 word", accept_data_o, 32'h04000000);
    chk("R5 irq low", {31'b0, irq_o}, 0);
    do_eoi(32'hff000015);
    chk("R6 eoi", {31'b0, c_eoi}, 1);
    chk("R6 eoi src", {8'b0, c_eoi_src}, 32'h15);
    chk("R7 resend", {31'b0, c_rs}, 1);
    chk("R6 prio", accept_data_o, 32'hff000000);
  endtask

  task automatic t_cppr_lower();
    offer(24'd30, 8'h10);
    wr_cppr(8'h10);
    chk("R8 reject", {31'b0, c_rej}, 1);
    chk("R8 reject src", {8'b0, c_rej_src}, 32'd30);
    chk("R8 word", accept_data_o, 32'h10000000);
    chk("R8 irq", {31'b0, irq_o}, 0);
    wr_cppr(8'h08);
    chk("R8 empty quiet", {30'b0, c_rej, c_rs}, 0);
    wr_cppr(8'hff);
    chk("R9 resend2", {31'b0, c_rs}, 1);
    offer(24'd31, 8'h05);
    wr_cppr(8'h20);
    chk("R8 keep favoured", {31'b0, c_rej}, 0);
    chk("R8 keep word", accept_data_o, 32'h2000001f);
    do_accept();
    chk("R5 prio from pend", accept_data_o, 32'h05000000);
    do_eoi(32'hff00001f);
    chk("R7 word", accept_data_o, 32'hff000000);
  endtask

  task automatic t_ipi();
    wr_ipi(8'h30);
    chk("R10 present", accept_data_o, 32'hff000002);
    chk("R10 irq", {31'b0, irq_o}, 1);
    offer(24'd40, 8'h10);
    chk("R4 ipi displaced", {8'b0, c_rej_src}, 32'd2);
    wr_ipi(8'h20);
    chk("R10 suppressed", {31'b0, c_rej}, 0);
    chk("R10 suppressed word", accept_data_o, 32'hff000028);
    wr_ipi(8'h08);
    chk("R10 displace src", {8'b0, c_rej_src}, 32'd40);
    chk("R10 word", accept_data_o, 32'hff000002);
    do_accept();
    chk("R5 ipi accept", accept_data_o, 32'h08000000);
    do_eoi(32'hff000002);
    chk("R7 ipi recheck", accept_data_o, 32'hff000002);
    chk("R7 ipi irq", {31'b0, irq_o}, 1);
    wr_ipi(8'hff);
    chk("R10 not below", accept_data_o, 32'hff000002);
    do_accept();
    do_eoi(32'hff000002);
    chk("R7 no ipi", accept_data_o, 32'hff000000);
  endtask

  task automatic t_collide();
    accept_i = 1; offer_valid_i = 1; offer_src_i = 24'd50; offer_prio_i = 8'h03;
    step();
    chk("R11 offer ignored rej", {31'b0, c_rej}, 0);
    chk("R11 word", accept_data_o, 32'hff000000);
    chk("R11 irq", {31'b0, irq_o}, 0);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    t_reset();
    t_offer_reject();
    t_raise_resend();
    t_offer_take();
    t_accept_eoi();
    t_cppr_lower();
    t_ipi();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule